// File: doc/BRIEF.md
# Protection-Aware Chip Erase Sequencer

This block sits behind a serial deserializer. It watches the byte stream of each select frame for the four-byte whole-array erase command. When such a command is framed by a rising chip select, the block erases every sector that software has not shielded. It cannot erase the whole array in one step. Instead it hands off to the cell erase engine one sector at a time and skips every sector whose write-protect or lockdown bit is set.

A frame is the span during which `cs_n` is low. Each byte the deserializer completes during a frame arrives as a one-cycle `rx_valid` strobe with `rx_byte`. Only the first four bytes of a frame are decoded. The command takes effect at the clock edge where `cs_n` is first seen high again. After that, the block raises `busy` and looks for the lowest eligible sector. It presents that sector on `erase_sector` with `erase_req` held high until the erase engine returns `erase_done`. Then it looks for the next eligible sector above it. When no eligible sector remains, `busy` falls.

Top module: `chip_erase_ctrl`

## Requirements
- R1: After synchronous reset, `busy` and `erase_req` are low.
- R2: A frame whose first four bytes are C7h, 94h, 80h, 9Ah in that order starts an erase. `busy` is high in the cycle after the clock edge at which `cs_n` is first sampled high.
- R3: If any of the first four bytes of a frame differs from its position in that sequence, the frame starts nothing and `busy` stays low.
- R4: A frame that ends after fewer than four bytes starts nothing.
- R5: Bytes after the fourth byte of a frame have no effect on whether the frame starts an erase.
- R6: No erase starts while `cs_n` is still low, even after all four command bytes have arrived.
- R7: A sector whose bit is set in `prot_mask` or in `lock_mask` is never requested. Every other sector is requested exactly once per erase. Requests come in ascending index order, and bit i of each mask refers to sector i.
- R8: Only one request is outstanding at a time. `erase_req` stays high with a stable `erase_sector` until `erase_done` is sampled high. It is then low for at least one cycle.
- R9: If every sector is masked, `busy` is high for exactly one cycle and no request is made.
- R10: `busy` is high whenever `erase_req` is high. It falls one cycle after the last `erase_done`. A command that completes while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low, synchronous to clk |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| prot_mask | input | NUM_SECT | Write-protect bit per sector |
| lock_mask | input | NUM_SECT | Lockdown bit per sector |
| erase_done | input | 1 | Erase engine finished the requested sector |
| erase_req | output | 1 | Sector erase request, held until erase_done |
| erase_sector | output | clog2(NUM_SECT) | Index of the requested sector |
| busy | output | 1 | Whole-array erase in progress |

## Verification
The bench targets frames that come close to the command but are not it: a wrong third byte, a frame cut short after three bytes, and a correct frame padded with trailing bytes. A decoder that checks too little would start erases on the first two. A decoder that checks trailing bytes would miss the third. Mask sets place the only eligible sectors at indices 0, 3 and 31. An off-by-one in the search window or in the wrap at the top would skip or repeat a sector. A fully masked array catches a walker that stays busy for more than one cycle or issues a request anyway. The bench also sends a second full command during a slow erase. A design that restarted on it would issue the sector a second time.

// File: rtl/ce_pkg.sv
package ce_pkg;

    localparam int CMD_LEN = 4;
    localparam int CNT_W   = $clog2(CMD_LEN + 1);

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_REQ  = 2'd2
    } walk_st_e;

    // Expected byte at each position of the erase command
    function automatic byte_t cmd_byte(input logic [CNT_W-1:0] pos);
        case (pos)
            CNT_W'(0): cmd_byte = 8'hC7;
            CNT_W'(1): cmd_byte = 8'h94;
            CNT_W'(2): cmd_byte = 8'h80;
            default:   cmd_byte = 8'h9A;
        endcase
    endfunction

endpackage

// File: rtl/ce_cmd_decoder.sv
module ce_cmd_decoder
    import ce_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  rx_valid,
    input  byte_t rx_byte,
    output logic  start
);

    logic             cs_q;
    logic [CNT_W-1:0] cnt;
    logic             match;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            cnt   <= '0;
            match <= 1'b1;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                cnt   <= '0;
                match <= 1'b1;
            end else if (rx_valid && (cnt < CNT_W'(CMD_LEN))) begin
                cnt <= cnt + 1'b1;
                if (rx_byte != cmd_byte(cnt))
                    match <= 1'b0;
            end
        end
    end

    assign start = cs_n && !cs_q && match && (cnt == CNT_W'(CMD_LEN));

    // R6: a start only ever follows a cycle in which select was low
    a_r6_start_on_rise: assert property (@(posedge clk) disable iff (rst)
        start |-> (cs_n && !$past(cs_n)));

    // R5: once the count is complete, further bytes in the frame leave it there
    a_r5_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && cnt == CNT_W'(CMD_LEN)) |=> (cs_n || cnt == CNT_W'(CMD_LEN)));

endmodule

// File: rtl/ce_sector_walker.sv
module ce_sector_walker
    import ce_pkg::*;
#(
    parameter int N = 32,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         erase_done,
    input  logic [N-1:0] elig,
    output logic         erase_req,
    output logic [W-1:0] erase_sector,
    output logic         busy
);

    walk_st_e     st;
    logic [W:0]   from;
    logic [W-1:0] sec;
    logic [N-1:0] window;
    logic         hit;
    logic [W-1:0] pick;

    // Eligible sectors at or above the search start, lowest one wins
    always_comb begin
        for (int i = 0; i < N; i++)
            window[i] = elig[i] && ((W+1)'(i) >= from);
        hit  = 1'b0;
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (window[i]) begin
                hit  = 1'b1;
                pick = W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            from <= '0;
            sec  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st   <= ST_SCAN;
                    from <= '0;
                end
                ST_SCAN: if (hit) begin
                    st  <= ST_REQ;
                    sec <= pick;
                end else begin
                    st <= ST_IDLE;
                end
                ST_REQ: if (erase_done) begin
                    st   <= ST_SCAN;
                    from <= {1'b0, sec} + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (st != ST_IDLE);
    assign erase_req    = (st == ST_REQ);
    assign erase_sector = sec;

    // R7: successive requests climb strictly
    a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SCAN && hit && from != '0) |-> ({1'b0, pick} >= from));

endmodule

// File: rtl/chip_erase_ctrl.sv
module chip_erase_ctrl
    import ce_pkg::*;
#(
    parameter int NUM_SECT = 32,
    localparam int SECT_W = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic [NUM_SECT-1:0] prot_mask,
    input  logic [NUM_SECT-1:0] lock_mask,
    input  logic                erase_done,
    output logic                erase_req,
    output logic [SECT_W-1:0]   erase_sector,
    output logic                busy
);

    logic                start;
    logic [NUM_SECT-1:0] elig;

    assign elig = ~(prot_mask | lock_mask);

    ce_cmd_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .start    (start)
    );

    ce_sector_walker #(.N(NUM_SECT)) u_walk (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .erase_done   (erase_done),
        .elig         (elig),
        .erase_req    (erase_req),
        .erase_sector (erase_sector),
        .busy         (busy)
    );

    // R8: a request holds its sector until done
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (erase_req && !erase_done) |=> (erase_req && $stable(erase_sector)));

    // R8: a gap follows every completed request
    a_r8_gap: assert property (@(posedge clk) disable iff (rst)
        (erase_req && erase_done) |=> !erase_req);

    // R7: no shielded sector is ever requested
    a_r7_masked_skip: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_req) |-> !(prot_mask[erase_sector] || lock_mask[erase_sector]));

    // R10: requests only inside a busy window
    a_r10_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        erase_req |-> busy);

endmodule

// File: tb/chip_erase_ctrl_tb_top.sv
module chip_erase_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [31:0] prot_mask = '0;
    logic [31:0] lock_mask = '0;
    logic        erase_done = 1'b0;
    logic        erase_req;
    logic [4:0]  erase_sector;
    logic        busy;

    always #10 clk = ~clk;

    chip_erase_ctrl dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .prot_mask(prot_mask), .lock_mask(lock_mask), .erase_done(erase_done),
        .erase_req(erase_req), .erase_sector(erase_sector), .busy(busy)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [7:0] frame_q[$];
    bit m_cs_prev = 1'b1;
    bit m_busy = 1'b0;
    bit m_req  = 1'b0;
    int m_sec  = 0;
    int pend_q[$];

    always @(posedge clk) begin
        bit launch;
        launch = 1'b0;
        if (rst) begin
            frame_q.delete(); pend_q.delete();
            m_cs_prev = 1'b1; m_busy = 1'b0; m_req = 1'b0;
        end else begin
            if (!cs_n && rx_valid) frame_q.push_back(rx_byte);
            if (cs_n && !m_cs_prev && frame_q.size() >= 4) begin
                if (frame_q[0] == 8'hC7 && frame_q[1] == 8'h94 &&
                    frame_q[2] == 8'h80 && frame_q[3] == 8'h9A)
                    launch = 1'b1;
            end
            if (cs_n) frame_q.delete();
            m_cs_prev = cs_n;
            if (!m_busy) begin
                if (launch) begin
                    for (int s = 0; s < 32; s++)
                        if (!prot_mask[s] && !lock_mask[s]) pend_q.push_back(s);
                    m_busy = 1'b1;
                    m_req  = 1'b0;
                end
            end else if (m_req) begin
                if (erase_done) m_req = 1'b0;
            end else if (pend_q.size() == 0) begin
                m_busy = 1'b0;
            end else begin
                m_req = 1'b1;
                m_sec = pend_q.pop_front();
            end
        end
    end

    // Per-cycle comparison, counters and erase engine responder
    int reqs = 0;
    int bcyc = 0;
    int dly  = 2;
    int held = 0;
    bit req_q = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == m_busy, "R10 busy vs model", busy, m_busy);
            chk(erase_req == m_req, "R8 request vs model", erase_req, m_req);
            if (erase_req && m_req)
                chk(int'(erase_sector) == m_sec, "R7 sector order", erase_sector, m_sec);
            if (erase_req && !req_q) reqs++;
            if (busy) bcyc++;
        end
        req_q = erase_req;
        if (erase_done) begin
            erase_done = 1'b0;
            held = 0;
        end else if (erase_req) begin
            held++;
            if (held >= dly) erase_done = 1'b1;
        end else begin
            held = 0;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic cs_low();  @(negedge clk); cs_n = 1'b0; endtask
    task automatic cs_high(); @(negedge clk); cs_n = 1'b1; endtask

    task automatic full_cmd();
        send(8'hC7); send(8'h94); send(8'h80); send(8'h9A);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        for (int k = 0; k < 3000; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic clr();
        @(posedge clk); reqs = 0; bcyc = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(erase_req == 1'b0, "R1 request after reset", erase_req, 0);

        // R2 / R7: mixed masks, 26 eligible sectors
        prot_mask = 32'h0000_00F0; lock_mask = 32'h8000_0001; dly = 2;
        clr();
        cs_low(); full_cmd(); cs_high();
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after select rise", busy, 1);
        wait_idle();
        chk(reqs == 26, "R7 eligible request count", reqs, 26);

        // R3: wrong third byte
        clr();
        cs_low(); send(8'hC7); send(8'h94); send(8'h81); send(8'h9A); cs_high();
        repeat (10) @(negedge clk);
        chk(bcyc == 0, "R3 wrong byte busy cycles", bcyc, 0);

        // R4: short frame
        clr();
        cs_low(); send(8'hC7); send(8'h94); send(8'h80); cs_high();
        repeat (10) @(negedge clk);
        chk(bcyc == 0, "R4 short frame busy cycles", bcyc, 0);

        // R5 / R6: trailing bytes, select held low; only sectors 3 and 31 eligible
        prot_mask = 32'h0000_FFF7; lock_mask = 32'h7FFF_0000; dly = 3;
        clr();
        cs_low(); full_cmd(); send(8'h55); send(8'hAA);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R6 no start while select low", busy, 0);
        cs_high();
        @(negedge clk);
        chk(busy == 1'b1, "R5 trailing bytes still start", busy, 1);
        wait_idle();
        chk(reqs == 2, "R7 sectors 3 and 31 requested", reqs, 2);

        // R9: every sector masked
        prot_mask = 32'h0F0F_0F0F; lock_mask = 32'hF0F0_F0F0;
        clr();
        cs_low(); full_cmd(); cs_high();
        repeat (8) @(negedge clk);
        chk(bcyc == 1, "R9 busy cycles all masked", bcyc, 1);
        chk(reqs == 0, "R9 no request all masked", reqs, 0);

        // R10: second command during a slow erase of sector 0 only
        prot_mask = 32'hFFFF_FFFE; lock_mask = '0; dly = 20;
        clr();
        cs_low(); full_cmd(); cs_high();
        cs_low(); full_cmd(); cs_high();
        wait_idle();
        repeat (10) @(negedge clk);
        chk(reqs == 1, "R10 command while busy ignored", reqs, 1);
        chk(busy == 1'b0, "R10 idle after single erase", busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule